// File: doc/BRIEF.md
# Long-Word Almost-Empty Flag for a Dual-Clock FIFO

This block produces the read-side almost-empty indication for a two-clock FIFO whose storage unit is a 36-bit long word. Each port may move data as a full long word, as two 18-bit halves or as four 9-bit quarters. The block counts long words on both sides and carries the write pointer into the read clock domain as Gray code through a synchronizer. It then drives a registered, active-low flag that compares the fill level with a threshold X, where X is captured at reset.

A sub-word counter on each port advances that port's long-word pointer only on the beat that completes a long word. Partial long words therefore never change the flag. A read that completes a long word lowers the flag on the same read edge. A completed write reaches the flag only after it has crossed the synchronizer, which takes two read edges and can take three when the edges are close together.

Top module: `aef_almost_empty`

## Requirements
- R1: While `rst` is high at a rising edge of either clock, that side's pointer and sub-word counter clear, `ae_n` is driven low, and `ae_offset` is captured as X.
- R2: With no write in flight, `ae_n` is 0 when the fill level (long words written minus long words read, modulo 2^(ADDR_W+1)) is X or less, and 1 when it is X+1 or more.
- R3: A read beat that completes a long word and leaves the fill level at X or less drives `ae_n` low at that same read clock edge.
- R4: `rd_size` encoding: 0 means one beat per long word, 1 means two beats, 2 means four beats, and 3 behaves as 0. Read beats that do not complete a long word leave `ae_n` unchanged.
- R5: `wr_size` uses the same encoding as `rd_size`. Only the write beat that completes a long word adds to the fill level.
- R6: After a completing write lifts the fill level above X, `ae_n` stays low through the first read edge and is high within three read cycles.
- R7: A beat is taken only at a rising clock edge with that port's enable high. While both enables are low, `ae_n` does not change.
- R8: Changes on `ae_offset` after reset have no effect on `ae_n`.
- R9: The Gray-coded write pointer changes in at most one bit per write clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write beat enable |
| wr_size | input | 2 | Write port width select (0 long, 1 half, 2 quarter) |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read beat enable |
| rd_size | input | 2 | Read port width select (0 long, 1 half, 2 quarter) |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| ae_offset | input | ADDR_W+1 | Threshold X, sampled during reset |
| ae_n | output | 1 | Almost-empty flag, low while the fill level is at or below X |

## Verification
The flag is driven with single long-word writes and reads that step the fill level across X in both directions. The exact value after each step shows whether the threshold is off by one or whether the flag falls late. Quarter and half beats on each side, some of them stopped partway through a long word, show whether partial transfers leak into the count. A freely running stream with unrelated clocks and random gaps, in which reads are taken only while the flag is high, checks every read cycle that the flag is never high at or below X and never trails a rise by more than three cycles. A second reset with a new threshold, and a threshold change made without a reset, show the difference between a captured X and a live one.

// File: rtl/aef_pkg.sv
package aef_pkg;

    typedef enum logic [1:0] {
        SZ_LONG = 2'd0,
        SZ_HALF = 2'd1,
        SZ_QUAR = 2'd2,
        SZ_RSVD = 2'd3
    } port_size_e;

    localparam int SUB_W = 2;

    // index of the beat that completes a long word
    function automatic logic [SUB_W-1:0] final_beat(port_size_e s);
        case (s)
            SZ_HALF: return SUB_W'(1);
            SZ_QUAR: return SUB_W'(3);
            default: return SUB_W'(0);
        endcase
    endfunction

    function automatic logic [31:0] bin_to_gray(logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/aef_beat_ptr.sv
module aef_beat_ptr
    import aef_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [1:0]       size,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] ptr_nxt,
    output logic             adv
);

    port_size_e       sz;
    logic [SUB_W-1:0] sub;
    logic             at_last;

    assign sz      = port_size_e'(size);
    assign at_last = (sub >= final_beat(sz));
    assign adv     = en & at_last;
    assign ptr_nxt = ptr + PTR_W'(adv);

    always_ff @(posedge clk) begin
        if (rst) begin
            sub <= '0;
            ptr <= '0;
        end else begin
            ptr <= ptr_nxt;
            if (en) begin
                sub <= at_last ? '0 : sub + SUB_W'(1);
            end
        end
    end

endmodule

// File: rtl/aef_gray_sync.sv
module aef_gray_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_pre,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q_pre = stg[STAGES-2];
    assign q     = stg[STAGES-1];

endmodule

// File: rtl/aef_almost_empty.sv
module aef_almost_empty
    import aef_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [1:0]        wr_size,
    input  logic              rd_clk,
    input  logic              rd_en,
    input  logic [1:0]        rd_size,
    input  logic              rst,
    input  logic [ADDR_W:0]   ae_offset,
    output logic              ae_n
);

    localparam int PTR_W = ADDR_W + 1;

    // write domain
    logic [PTR_W-1:0] w_ptr, w_nxt, wgray;
    logic             w_adv;

    aef_beat_ptr #(.PTR_W(PTR_W)) i_wr_ptr (
        .clk(wr_clk), .rst(rst), .en(wr_en), .size(wr_size),
        .ptr(w_ptr), .ptr_nxt(w_nxt), .adv(w_adv)
    );

    always_ff @(posedge wr_clk) begin
        if (rst) wgray <= '0;
        else     wgray <= PTR_W'(bin_to_gray(32'(w_nxt)));
    end

    // crossing
    logic [PTR_W-1:0] wg_pre, wg_sync, wbin_nxt, wsync_bin;

    aef_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk(rd_clk), .rst(rst), .d(wgray), .q_pre(wg_pre), .q(wg_sync)
    );

    assign wbin_nxt  = PTR_W'(gray_to_bin(32'(wg_pre)));
    assign wsync_bin = PTR_W'(gray_to_bin(32'(wg_sync)));

    // read domain
    logic [PTR_W-1:0] r_ptr, r_nxt, x_q, fill_nxt;
    logic             rd_adv;

    aef_beat_ptr #(.PTR_W(PTR_W)) i_rd_ptr (
        .clk(rd_clk), .rst(rst), .en(rd_en), .size(rd_size),
        .ptr(r_ptr), .ptr_nxt(r_nxt), .adv(rd_adv)
    );

    assign fill_nxt = wbin_nxt - r_nxt;

    always_ff @(posedge rd_clk) begin
        if (rst) begin
            x_q  <= ae_offset;
            ae_n <= 1'b0;
        end else begin
            ae_n <= !(fill_nxt <= x_q);
        end
    end

endmodule

// File: rtl/aef_almost_empty_chk.sv
module aef_almost_empty_chk #(
    parameter int PTR_W = 5
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst,
    input logic             ae_n,
    input logic             rd_adv,
    input logic [PTR_W-1:0] wsync_bin,
    input logic [PTR_W-1:0] wgray
);

    // R1: reset forces the almost-empty state
    p_reset_low_r1: assert property (@(posedge rd_clk) rst |=> !ae_n);

    // R3: the flag can only fall on a read that completes a long word
    p_fall_needs_read_r3: assert property (@(posedge rd_clk) disable iff (rst)
        $fell(ae_n) |-> $past(rd_adv));

    // R6: the flag can only rise when new write progress arrives
    p_rise_needs_sync_r6: assert property (@(posedge rd_clk) disable iff (rst)
        $rose(ae_n) |-> (wsync_bin != $past(wsync_bin)));

    // R9: Gray pointer moves by a single bit per write edge
    p_gray_step_r9: assert property (@(posedge wr_clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);

endmodule

bind aef_almost_empty aef_almost_empty_chk #(.PTR_W(PTR_W)) i_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .ae_n(ae_n),
    .rd_adv(rd_adv), .wsync_bin(wsync_bin), .wgray(wgray)
);

// File: tb/test_aef_almost_empty.sv
`timescale 1ns/1ps
module test_aef_almost_empty;

    localparam int ADDR_W = 4;

    logic             wr_clk = 0, rd_clk = 0;
    logic             wr_en = 0, rd_en = 0, rst = 1;
    logic [1:0]       wr_size = 0, rd_size = 0;
    logic [ADDR_W:0]  ae_offset = 0;
    logic             ae_n;

    aef_almost_empty #(.ADDR_W(ADDR_W)) i_aef_almost_empty (
        .wr_clk(wr_clk), .wr_en(wr_en), .wr_size(wr_size),
        .rd_clk(rd_clk), .rd_en(rd_en), .rd_size(rd_size),
        .rst(rst), .ae_offset(ae_offset), .ae_n(ae_n)
    );

    always #2   rd_clk = ~rd_clk;   // 250 MHz
    always #3.1 wr_clk = ~wr_clk;   // unrelated

    int checks = 0, failures = 0;
    int wr_long = 0, rd_long = 0, wsub = 0, rsub = 0, thr = 0;
    int lag = 0;
    bit mon_on = 0;
    logic  exp_q[$];
    string req_q[$];

    function automatic int beats(logic [1:0] s);
        return (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 1;
    endfunction

    function automatic int fill();
        return wr_long - rd_long;
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // driver: write beats
    task automatic wr_beats(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk) wr_en = 1;
            @(posedge wr_clk);
            wsub++;
            if (wsub >= beats(wr_size)) begin wsub = 0; wr_long++; end
        end
        @(negedge wr_clk) wr_en = 0;
    endtask

    // driver: read beats, pushing expected flag values to the scoreboard
    task automatic rd_beats(int n, bit chk, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk) rd_en = 1;
            @(posedge rd_clk);
            rsub++;
            if (rsub >= beats(rd_size)) begin rsub = 0; rd_long++; end
            if (chk) begin
                exp_q.push_back(fill() > thr);
                req_q.push_back(req);
            end
        end
        @(negedge rd_clk) rd_en = 0;
    endtask

    task automatic settle_check(string req);
        repeat (6) @(negedge rd_clk);
        check(req, ae_n, fill() > thr);
    endtask

    task automatic do_reset(int x);
        mon_on = 0;
        rst = 1; wr_en = 0; rd_en = 0;
        ae_offset = (ADDR_W+1)'(x);
        thr = x;
        repeat (5) @(negedge rd_clk);
        wr_long = 0; rd_long = 0; wsub = 0; rsub = 0; lag = 0;
        check("R1 flag low in reset", ae_n, 1'b0);
        rst = 0;
        @(negedge rd_clk);
        check("R1 flag low after reset", ae_n, 1'b0);
        mon_on = 1;
    endtask

    // monitor: scoreboard pops plus running invariants (R2, R6)
    always @(negedge rd_clk) begin
        if (exp_q.size() > 0) check(req_q.pop_front(), ae_n, exp_q.pop_front());
        if (mon_on && !rst) begin
            checks++;
            if (ae_n && fill() <= thr) begin
                failures++;
                $display("FAIL R2 flag high at fill=%0d actual=1 expected=0", fill());
            end
            if (fill() > thr && !ae_n) lag++; else lag = 0;
            if (lag > 3) begin
                failures++;
                $display("FAIL R6 rise late lag=%0d actual=0 expected=1", lag);
                lag = 0;
            end
        end
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        do_reset(3);

        // R2 threshold steps in long-word mode
        wr_beats(3);
        settle_check("R2 fill==X low");
        wr_beats(1);
        @(negedge rd_clk);
        check("R6 not high after one read edge", ae_n, 1'b0);
        settle_check("R2 fill==X+1 high");

        // R3 same-edge fall
        rd_beats(1, 1, "R3 fall on completing read");
        @(negedge rd_clk);

        // R7 idle enables
        repeat (10) @(negedge rd_clk);
        settle_check("R7 idle holds flag");
        wr_beats(1);
        settle_check("R2 back above X");
        rd_beats(1, 1, "R7 read pointer held while idle");

        // R5 quarter-beat writes
        wr_size = 2'd2;
        wr_beats(3);
        settle_check("R5 partial write not counted");
        wr_beats(1);
        settle_check("R5 completing write counted");

        // R4 half-beat reads
        wr_size = 2'd0;
        wr_beats(1);
        settle_check("R2 fill 5");
        rd_size = 2'd1;
        rd_beats(4, 1, "R4 half reads");
        // R4 quarter-beat reads
        wr_beats(1);
        settle_check("R2 fill 4");
        rd_size = 2'd2;
        rd_beats(4, 1, "R4 quarter reads");
        // R4 reserved code behaves as long word
        wr_beats(1);
        settle_check("R2 fill 4 again");
        rd_size = 2'd3;
        rd_beats(1, 1, "R4 reserved size as long");
        rd_size = 2'd0;

        // R8 offset change without reset
        ae_offset = '0;
        settle_check("R8 offset change ignored");

        // stream with unrelated clocks (R2/R6 invariants in monitor)
        fork
            begin
                repeat (500) begin
                    if (fill() < 14 && $urandom_range(0, 2) != 0) wr_beats(1);
                    else @(negedge wr_clk);
                end
            end
            begin
                repeat (500) begin
                    @(negedge rd_clk);
                    if (ae_n && $urandom_range(0, 1) == 1) rd_beats(1, 0, "");
                end
            end
        join
        settle_check("R2 after stream");

        // second reset with X=0, half-beat writes
        do_reset(0);
        wr_size = 2'd1;
        wr_beats(1);
        settle_check("R5 half write not counted");
        wr_beats(1);
        settle_check("R2 fill 1 above X=0");
        rd_beats(1, 1, "R3 fall to empty");
        @(negedge rd_clk);

        summary();
        $finish;
    end

endmodule